// File: doc/BRIEF.md
# Multiplexed DRAM Cycle Sequencer with RAS-only Refresh

This block drives one external 16-bit DRAM on behalf of three on-chip requester classes: the synthesis engine, instruction fetch and the control processor's data accesses. Each requester presents a 24-bit linear word address, a write flag and write data, and holds its request until it sees a one-clock grant. The block then runs a fixed six-clock cycle on the multiplexed 12-bit address bus with RAS, CAS, an active-low write enable and an active-low cycle select. It also places a two-bit code on a cycle-type output that tells the outside world which class owns the bus.

The row and column halves are scrambled out of the linear address. The three upper row bits and the three upper column bits interleave the top six linear bits, so a board can pick memory size by wiring only the upper lines it needs. A free-running interval counter earns one refresh credit every `REF_PERIOD` clocks. The credit is spent on a RAS-only cycle that puts a 12-bit refresh row counter on the bus. The strobes move only when a request or a refresh credit is waiting. Otherwise they rest high.

Top module: `dram_seq_ctrl`

## Requirements
- R1: Every cycle lasts six clocks (clock 1 to clock 6). RAS is low in clocks 2, 3 and 4 and high in clocks 1, 5 and 6.
- R2: In a read or write cycle CAS is low in clocks 3, 4 and 5, so it falls one clock after RAS. It is high in every other clock.
- R3: The row address is on the address bus in clocks 1 and 2, so it is stable for one clock before RAS falls.
- R4: The row address, from bit 11 down to bit 0, carries linear address bits 22, 20, 18, 8, 7, 6, 5, 4, 3, 2, 1, 0.
- R5: The column address is on the bus in clocks 3 to 6. From bit 11 down to bit 0 it carries linear bits 23, 21, 19, 17, 16, 15, 14, 13, 12, 11, 10, 9.
- R6: A write uses early write. The write enable is low and the data bus is driven with the write data (output enable 1) in clocks 2 to 5. In all other clocks the write enable is high and the data output reads 0 with output enable 0.
- R7: A refresh cycle is RAS-only: CAS and the write enable stay high. The address bus carries the refresh row in all six clocks. The refresh row is 0 for the first refresh after reset and steps by one (mod 4096) per refresh.
- R8: The active-low cycle select is low in clocks 2 to 5 of every cycle, refresh included, and high otherwise.
- R9: The cycle-type output reads 01 when idle and during refresh. It reads 00 for a synthesis cycle (class 0), 10 for an instruction fetch (class 1) and 11 for a processor access (class 2).
- R10: With no request and no refresh credit, RAS, CAS, write enable and cycle select are high, the address bus reads 0 and the data output is disabled. This is also the state directly after reset.
- R11: A refresh credit is earned on the `REF_PERIOD`-th clock after reset and every `REF_PERIOD` clocks after that. A waiting credit starts a refresh at the next cycle boundary, ahead of any request.
- R12: At a cycle boundary the lowest-numbered waiting class wins. Its grant bit is high for exactly clock 1 of its cycle. A new cycle may start in the clock right after clock 6.
- R13: A read samples the data input at the end of clock 5. The sampled value is presented with the read-valid pulse in clock 6 and held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 3 | Request per class (0 synthesis, 1 fetch, 2 processor), held until granted |
| req_we_i | input | 3 | Write flag per class |
| req_addr_i | input | 72 | 24-bit linear word address per class, class c in bits [24c+23:24c] |
| req_wdata_i | input | 48 | Write data per class, class c in bits [16c+15:16c] |
| gnt_o | output | 3 | One-clock grant per class |
| rd_data_o | output | 16 | Last read data |
| rd_valid_o | output | 1 | Read data valid pulse |
| dram_a_o | output | 12 | Multiplexed row/column address |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cyc_cs_n_o | output | 1 | Cycle-active select, active low |
| dq_o | output | 16 | Write data to memory |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| dq_i | input | 16 | Read data from memory |
| cyc_type_o | output | 2 | Requester class code of the current cycle |

## Verification
A request that is high at an edge on an idle bus is answered by the grant in the next clock. The strobes, address halves, write enable and select then follow at fixed offsets of one to five clocks from that grant. The read result shows up five clocks after the grant, and a refresh credit is served within six clocks of being earned. The bench keeps a behavioural model that advances on the rising edge with the same input values the design sees. It compares every output at the falling edge, so each expected value sits in exactly the clock in which the register that drives it has changed. A memory stub latches row and column from the pins, which checks the address scrambling end to end through read-back.

// File: rtl/dram_seq_pkg.sv
// Shared constants for the DRAM cycle sequencer: phase positions inside the
// six-clock cycle, the cycle kinds and the requester-class codes.
// Assumes exactly three requester classes with fixed codes.
package dram_seq_pkg;
    localparam int LIN_W   = 24;
    localparam int ROW_W   = 12;
    localparam int NUM_CLS = 3;

    // Phase index 0..5 is clock 1..6 of a cycle.
    localparam logic [2:0] PH_ROW    = 3'd0;
    localparam logic [2:0] PH_RAS    = 3'd1;
    localparam logic [2:0] PH_CAS    = 3'd2;
    localparam logic [2:0] PH_RAS_UP = 3'd4;
    localparam logic [2:0] PH_CAS_UP = 3'd5;
    localparam logic [2:0] PH_LAST   = 3'd5;

    typedef enum logic [1:0] {
        KIND_REF = 2'd0,
        KIND_RD  = 2'd1,
        KIND_WR  = 2'd2
    } cyc_kind_e;

    localparam logic [1:0] TYPE_IDLE  = 2'b01;
    localparam logic [1:0] TYPE_SYN   = 2'b00;
    localparam logic [1:0] TYPE_FETCH = 2'b10;
    localparam logic [1:0] TYPE_PROC  = 2'b11;

    // Map a requester class to its bus code.
    function automatic logic [1:0] class_code(input logic [1:0] cls);
        case (cls)
            2'd0:    return TYPE_SYN;
            2'd1:    return TYPE_FETCH;
            default: return TYPE_PROC;
        endcase
    endfunction
endpackage

// File: rtl/dram_addr_scramble.sv
// Splits a 24-bit linear word address into the 12-bit row and column words.
// The top six linear bits alternate between row and column so that smaller
// memories need only some of the upper lines. Purely combinational.
module dram_addr_scramble
    import dram_seq_pkg::*;
(
    input  logic [LIN_W-1:0] lin_addr,
    output logic [ROW_W-1:0] row_addr,
    output logic [ROW_W-1:0] col_addr
);
    localparam int LOW_ROW = 9;   // linear bits 8..0 go straight to row 8..0
    localparam int MID_COL = 9;   // linear bits 17..9 go to column 8..0

    // Contiguous parts of the mapping.
    for (genvar i = 0; i < LOW_ROW; i++) begin : g_row_low
        assign row_addr[i] = lin_addr[i];
    end
    for (genvar i = 0; i < MID_COL; i++) begin : g_col_mid
        assign col_addr[i] = lin_addr[i + 9];
    end

    // Interleaved upper bits.
    assign row_addr[11] = lin_addr[22];
    assign row_addr[10] = lin_addr[20];
    assign row_addr[9]  = lin_addr[18];
    assign col_addr[11] = lin_addr[23];
    assign col_addr[10] = lin_addr[21];
    assign col_addr[9]  = lin_addr[19];
endmodule

// File: rtl/dram_refresh_sched.sv
// Refresh scheduler: an interval counter earns one refresh credit every
// REF_PERIOD clocks and a row counter supplies the next refresh row.
// Assumes the consumer spends a credit within REF_PERIOD clocks, so a
// single pending flag is enough.
module dram_refresh_sched #(
    parameter int REF_PERIOD = 512,
    parameter int ROW_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    output logic             pend_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int CNT_W = $clog2(REF_PERIOD);

    logic [CNT_W-1:0] interval_q;
    logic             tick;

    assign tick = (interval_q == CNT_W'(REF_PERIOD - 1));

    // Interval counter wrapping every REF_PERIOD clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    interval_q <= '0;
        else if (tick) interval_q <= '0;
        else           interval_q <= interval_q + 1'b1;
    end

    // Pending credit: set on each tick, cleared when a refresh starts.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_o <= 1'b0;
        else if (tick)   pend_o <= 1'b1;
        else if (take_i) pend_o <= 1'b0;
    end

    // Refresh row advances once per refresh taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      row_o <= '0;
        else if (take_i) row_o <= row_o + 1'b1;
    end
endmodule

// File: rtl/dram_req_arbiter.sv
// Fixed-priority arbiter: the lowest-numbered active request wins.
// Combinational; the caller decides when the result is used.
module dram_req_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx,
    output logic [N-1:0]         onehot
);
    localparam int IW = $clog2(N);

    // Scan from the top down so the lowest index is the last one to write idx.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    // Expand the winner to a one-hot vector.
    for (genvar g = 0; g < N; g++) begin : g_oh
        assign onehot[g] = any && (idx == IW'(g));
    end
endmodule

// File: rtl/dram_seq_ctrl.sv
// DRAM cycle sequencer. It runs six-clock read, early-write and RAS-only
// refresh cycles on a multiplexed address bus for three requester classes.
// Assumes requesters hold req_i (and its address/data) until granted, and
// that the memory returns read data by the last CAS-low clock.
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int REF_PERIOD = 512
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CLS-1:0]        req_i,
    input  logic [NUM_CLS-1:0]        req_we_i,
    input  logic [NUM_CLS*LIN_W-1:0]  req_addr_i,
    input  logic [NUM_CLS*DATA_W-1:0] req_wdata_i,
    output logic [NUM_CLS-1:0]        gnt_o,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      rd_valid_o,
    output logic [ROW_W-1:0]          dram_a_o,
    output logic                      ras_n_o,
    output logic                      cas_n_o,
    output logic                      we_n_o,
    output logic                      cyc_cs_n_o,
    output logic [DATA_W-1:0]         dq_o,
    output logic                      dq_oe_o,
    input  logic [DATA_W-1:0]         dq_i,
    output logic [1:0]                cyc_type_o
);
    localparam int CLS_W = $clog2(NUM_CLS);

    logic                busy_q;
    logic [2:0]          ph_q;
    cyc_kind_e           kind_q;
    logic [CLS_W-1:0]    cls_q;
    logic [LIN_W-1:0]    addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [ROW_W-1:0]    refrow_q;
    logic [NUM_CLS-1:0]  gnt_q;
    logic                rdv_q;
    logic [DATA_W-1:0]   rdd_q;

    logic                arb_any;
    logic [CLS_W-1:0]    arb_idx;
    logic [NUM_CLS-1:0]  arb_oh;
    logic                ref_pend;
    logic [ROW_W-1:0]    ref_row;
    logic [ROW_W-1:0]    row_w;
    logic [ROW_W-1:0]    col_w;
    logic                boundary;
    logic                start_ref;
    logic                start_req;

    dram_req_arbiter #(.N(NUM_CLS)) u_arb (
        .req    (req_i),
        .any    (arb_any),
        .idx    (arb_idx),
        .onehot (arb_oh)
    );

    dram_refresh_sched #(.REF_PERIOD(REF_PERIOD), .ROW_W(ROW_W)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (start_ref),
        .pend_o (ref_pend),
        .row_o  (ref_row)
    );

    dram_addr_scramble u_scr (
        .lin_addr (addr_q),
        .row_addr (row_w),
        .col_addr (col_w)
    );

    assign boundary  = !busy_q || (ph_q == PH_LAST);
    assign start_ref = boundary && ref_pend;
    assign start_req = boundary && !ref_pend && arb_any;

    // Cycle sequencer: advance the phase, or launch a refresh or a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            ph_q     <= PH_ROW;
            kind_q   <= KIND_REF;
            cls_q    <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            refrow_q <= '0;
            gnt_q    <= '0;
        end else begin
            gnt_q <= '0;
            if (busy_q && (ph_q != PH_LAST)) begin
                ph_q <= ph_q + 1'b1;
            end else if (start_ref) begin
                busy_q   <= 1'b1;
                ph_q     <= PH_ROW;
                kind_q   <= KIND_REF;
                refrow_q <= ref_row;
            end else if (start_req) begin
                busy_q  <= 1'b1;
                ph_q    <= PH_ROW;
                kind_q  <= req_we_i[arb_idx] ? KIND_WR : KIND_RD;
                cls_q   <= arb_idx;
                addr_q  <= req_addr_i[arb_idx*LIN_W +: LIN_W];
                wdata_q <= req_wdata_i[arb_idx*DATA_W +: DATA_W];
                gnt_q   <= arb_oh;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    // Read capture at the end of the last CAS-low clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q <= 1'b0;
            rdd_q <= '0;
        end else begin
            rdv_q <= busy_q && (kind_q == KIND_RD) && (ph_q == PH_CAS_UP - 3'd1);
            if (busy_q && (kind_q == KIND_RD) && (ph_q == PH_CAS_UP - 3'd1))
                rdd_q <= dq_i;
        end
    end

    // Pin decode from the phase and the cycle kind.
    always_comb begin
        logic ras_win, cas_win, sel_win, wr_cyc;
        ras_win = busy_q && (ph_q >= PH_RAS) && (ph_q < PH_RAS_UP);
        cas_win = busy_q && (kind_q != KIND_REF) && (ph_q >= PH_CAS) && (ph_q < PH_CAS_UP);
        sel_win = busy_q && (ph_q >= PH_RAS) && (ph_q < PH_CAS_UP);
        wr_cyc  = sel_win && (kind_q == KIND_WR);

        ras_n_o    = !ras_win;
        cas_n_o    = !cas_win;
        cyc_cs_n_o = !sel_win;
        we_n_o     = !wr_cyc;
        dq_oe_o    = wr_cyc;
        dq_o       = wr_cyc ? wdata_q : '0;

        if (!busy_q)                dram_a_o = '0;
        else if (kind_q == KIND_REF) dram_a_o = refrow_q;
        else if (ph_q < PH_CAS)     dram_a_o = row_w;
        else                        dram_a_o = col_w;

        if (busy_q && (kind_q != KIND_REF)) cyc_type_o = class_code(2'(cls_q));
        else                                cyc_type_o = TYPE_IDLE;
    end

    assign gnt_o      = gnt_q;
    assign rd_valid_o = rdv_q;
    assign rd_data_o  = rdd_q;
endmodule

// File: rtl/dram_seq_ctrl_chk.sv
// Protocol checker for the DRAM sequencer pins, bound to the top module.
// Assumes the synchronous active-low reset of the design.
module dram_seq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic        cs_n,
    input logic [11:0] dram_a,
    input logic        dq_oe,
    input logic [2:0]  gnt,
    input logic        rd_valid,
    input logic [1:0]  cyc_type
);
    p_ras_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !ras_n ##1 !ras_n ##1 ras_n);

    p_cas_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (!ras_n && $past(!ras_n) && $past(ras_n, 2)));

    p_cas_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |=> !cas_n ##1 !cas_n ##1 cas_n);

    p_row_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(dram_a));

    p_col_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |=> $stable(dram_a) ##1 $stable(dram_a));

    p_early_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> ($past(!we_n) && dq_oe));

    p_sel_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> !cs_n);

    p_cas_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> (cyc_type != 2'b01));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (we_n && !dq_oe));

    p_gnt_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_rdv_slot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($rose(cas_n) && we_n));

    p_precharge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n ##1 ras_n);
endmodule

bind dram_seq_ctrl dram_seq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n_o),
    .cas_n    (cas_n_o),
    .we_n     (we_n_o),
    .cs_n     (cyc_cs_n_o),
    .dram_a   (dram_a_o),
    .dq_oe    (dq_oe_o),
    .gnt      (gnt_o),
    .rd_valid (rd_valid_o),
    .cyc_type (cyc_type_o)
);

// File: tb/sim_dram_seq_ctrl.sv
module sim_dram_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int NC = 3;
    localparam int RP = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]    req_b = '0;
    logic [NC-1:0]    req_we_b = '0;
    logic [NC*AW-1:0] addr_b = '0;
    logic [NC*DW-1:0] data_b = '0;
    logic [NC-1:0]    gnt_o;
    logic [DW-1:0]    rd_data_o;
    logic             rd_valid_o;
    logic [11:0]      dram_a;
    logic             ras_n, cas_n, we_n, cs_n, dq_oe;
    logic [DW-1:0]    dq_o;
    logic [DW-1:0]    dq_i = '0;
    logic [1:0]       cyc_type;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_seq_ctrl #(.DATA_W(DW), .REF_PERIOD(RP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_b), .req_we_i(req_we_b),
        .req_addr_i(addr_b), .req_wdata_i(data_b), .gnt_o(gnt_o),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .dram_a_o(dram_a),
        .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .cyc_cs_n_o(cs_n),
        .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i), .cyc_type_o(cyc_type)
    );

    // Memory stub: latches row and column from the pins.
    logic [11:0] st_row = '0;
    logic st_ras_d = 1'b1, st_cas_d = 1'b1;
    logic [DW-1:0] st_mem [logic [23:0]];
    always @(negedge clk) begin
        if (!ras_n && st_ras_d) st_row = dram_a;
        if (!cas_n && st_cas_d) begin
            if (!we_n) st_mem[{st_row, dram_a}] = dq_o;
            else dq_i = st_mem.exists({st_row, dram_a}) ? st_mem[{st_row, dram_a}] : 16'hDEAD;
        end
        st_ras_d = ras_n;
        st_cas_d = cas_n;
    end

    // Reference model state.
    bit m_live = 0;
    int m_busy = 0, m_ph = 0, m_kind = 0, m_cls = 0;
    int m_refrow = 0, m_currow = 0, m_cnt = 0;
    bit m_pend = 0, m_rdv = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wd = '0, m_rdd = '0;
    logic [NC-1:0] m_gnt = '0;
    logic [DW-1:0] m_mem [logic [23:0]];

    function automatic logic [11:0] row_of(logic [23:0] a);
        return {a[22], a[20], a[18], a[8], a[7], a[6], a[5], a[4], a[3], a[2], a[1], a[0]};
    endfunction
    function automatic logic [11:0] col_of(logic [23:0] a);
        return {a[23], a[21], a[19], a[17], a[16], a[15], a[14], a[13], a[12], a[11], a[10], a[9]};
    endfunction

    // Model step: one clock of the requirement-level behaviour.
    always @(posedge clk) begin
        m_live = 1;
        if (!rst_n) begin
            m_busy = 0; m_ph = 0; m_kind = 0; m_cls = 0; m_refrow = 0; m_currow = 0;
            m_cnt = 0; m_pend = 0; m_rdv = 0; m_addr = '0; m_wd = '0; m_rdd = '0; m_gnt = '0;
        end else begin
            bit tick, take;
            tick = (m_cnt == RP - 1);
            m_cnt = tick ? 0 : m_cnt + 1;
            m_gnt = '0;
            take = 0;
            m_rdv = (m_busy != 0) && (m_ph == 4) && (m_kind == 1);
            if (m_rdv) m_rdd = m_mem.exists(m_addr) ? m_mem[m_addr] : 16'hDEAD;
            if (m_busy != 0 && m_ph < 5) m_ph++;
            else if (m_pend) begin
                take = 1; m_busy = 1; m_ph = 0; m_kind = 0;
                m_currow = m_refrow; m_refrow = (m_refrow + 1) % 4096;
            end else if (req_b != 0) begin
                int c;
                c = req_b[0] ? 0 : (req_b[1] ? 1 : 2);
                m_busy = 1; m_ph = 0; m_cls = c;
                m_kind = req_we_b[c] ? 2 : 1;
                m_addr = addr_b[c*AW +: AW];
                m_wd = data_b[c*DW +: DW];
                m_gnt[c] = 1'b1;
                if (m_kind == 2) m_mem[m_addr] = m_wd;
            end else m_busy = 0;
            if (tick) m_pend = 1;
            else if (take) m_pend = 0;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (m_live) begin
            bit b, rw, ref_c;
            logic [11:0] ea;
            b = (m_busy != 0);
            ref_c = b && m_kind == 0;
            rw = b && m_kind != 0;
            if (!b) begin
                chk("R10", "idle ras", ras_n, 1); chk("R10", "idle cas", cas_n, 1);
                chk("R10", "idle addr", dram_a, 0); chk("R10", "idle oe", dq_oe, 0);
                chk("R10", "idle sel", cs_n, 1);
            end else begin
                if (ref_c) chk("R11", "refresh ras", ras_n, !(m_ph >= 1 && m_ph <= 3));
                else chk("R1", "ras", ras_n, !(m_ph >= 1 && m_ph <= 3));
                chk("R8", "select", cs_n, !(m_ph >= 1 && m_ph <= 4));
            end
            if (ref_c) chk("R7", "refresh cas", cas_n, 1);
            else chk("R2", "cas", cas_n, !(rw && m_ph >= 2 && m_ph <= 4));
            chk("R6", "we", we_n, !(b && m_kind == 2 && m_ph >= 1 && m_ph <= 4));
            chk("R6", "dq", {dq_oe, dq_o},
                (b && m_kind == 2 && m_ph >= 1 && m_ph <= 4) ? {1'b1, m_wd} : 17'd0);
            if (ref_c) chk("R7", "refresh row", dram_a, m_currow[11:0]);
            else if (rw && m_ph < 2) chk("R4", "row addr R3", dram_a, row_of(m_addr));
            else if (rw) chk("R5", "col addr", dram_a, col_of(m_addr));
            chk("R9", "cycle type", cyc_type,
                (!rw) ? 2'b01 : (m_cls == 0 ? 2'b00 : (m_cls == 1 ? 2'b10 : 2'b11)));
            chk("R12", "grant", gnt_o, m_gnt);
            chk("R13", "read", {rd_valid_o, rd_data_o}, {m_rdv, m_rdd});
        end
    end

    task automatic one_op(int c, bit we, logic [23:0] a, logic [15:0] d);
        @(negedge clk);
        req_b[c] = 1'b1; req_we_b[c] = we;
        addr_b[c*AW +: AW] = a; data_b[c*DW +: DW] = d;
        do @(negedge clk); while (!gnt_o[c]);
        req_b[c] = 1'b0;
    endtask

    task automatic all_ops(logic [2:0] we, logic [23:0] base, logic [15:0] d);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            req_we_b[c] = we[c];
            addr_b[c*AW +: AW] = base + 24'(c * 24'h041111);
            data_b[c*DW +: DW] = d ^ 16'(c * 16'h1111);
        end
        req_b = 3'b111;
        while (req_b != 0) begin
            @(negedge clk);
            req_b = req_b & ~gnt_o;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R4 R5 R6: writes through each class with scrambled high bits
        one_op(0, 1, 24'hA55A3C, 16'h1234);
        one_op(1, 1, 24'h5AA5C3, 16'hBEEF);
        one_op(2, 1, 24'hFFFFFF, 16'hCAFE);
        one_op(2, 1, 24'h000000, 16'h0F0F);
        // R13: read-back plus an unwritten location
        one_op(1, 0, 24'hA55A3C, 16'h0);
        one_op(0, 0, 24'h5AA5C3, 16'h0);
        one_op(2, 0, 24'hFFFFFF, 16'h0);
        one_op(2, 0, 24'h000000, 16'h0);
        one_op(0, 0, 24'h123456, 16'h0);
        // R12: simultaneous requests, write then read
        all_ops(3'b111, 24'h800001, 16'h5555);
        all_ops(3'b000, 24'h800001, 16'h0);
        all_ops(3'b010, 24'h2AAAAA, 16'hA0A0);
        // R10 R11: idle window with refreshes only
        repeat (1200) @(negedge clk);
        // R11 R12: sustained traffic colliding with refresh credits
        for (int i = 0; i < 60; i++) begin
            all_ops(3'(i % 8), 24'(i * 24'h0A0B0D), 16'(i * 16'h0101));
        end
        repeat (20) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule